// File: doc/BRIEF.md
# Register-Pointer Serial Target

This block is a target on a two-wire serial bus (I2C-style, SCL and SDA). A host reaches a 16-byte register file through a stored pointer. SCL and SDA are brought into the system clock domain by a short synchroniser chain. The engine detects START, repeated START and STOP from those synchronised lines and matches a fixed 7-bit device address. It acknowledges the bytes it accepts by pulling SDA low through an output-enable. The block never drives SDA high.

A write transaction carries the address byte and then a command byte that loads the pointer. Every later byte in that write lands in the register the pointer selects, and the pointer steps by one after each data byte. A read transaction has no command byte. It returns bytes starting at the current pointer and steps the pointer after each byte it sends. The pointer survives the end of a transaction and is shared by reads and writes. A host therefore sets it with a write and then either issues a repeated START or ends with STOP before reading.

Location 0x0 is read-only. It returns the live level of the eight port pins, taken at the moment the byte is loaded for shifting out.

Top module: `i2c_regptr_target`

## Requirements
- R1: A byte whose upper seven bits equal the device address (default 0x3A) is acknowledged: SDA is pulled low for the whole ninth clock. SDA changes only after a falling SCL edge, a START or a STOP.
- R2: A byte with any other address gets no acknowledge. The rest of that transaction leaves SDA released and writes no register.
- R3: In a write (address LSB 0), the first byte after the address loads the pointer from its low four bits and is acknowledged. The next byte is stored at that register and is also acknowledged.
- R4: Further data bytes in one write go to successive registers. The pointer steps by one after each data byte and wraps from 0xF to 0x0.
- R5: A read (address LSB 1) returns bytes MSB first from the current pointer. The pointer steps by one after each byte, wraps from 0xF to 0x0, and the read continues while the host acknowledges.
- R6: After a write ends with STOP, the pointer keeps its stepped value, so a following read returns the register after the last one written.
- R7: A write made of only the address and a command byte, ended by STOP, sets the pointer used by the next read.
- R8: A repeated START after the command byte keeps the pointer and switches to a read, with no STOP in between.
- R9: Register 0x0 reads back the port pins as they are at load time. A write to 0x0 is acknowledged, changes nothing, and still steps the pointer.
- R10: A host NACK after a read byte ends the read. SDA stays released for any further clocks until the next START, the pointer does not move again, and a STOP always releases SDA.
- R11: A START or STOP that arrives before the eighth bit of a data byte discards that byte, and no register changes.
- R12: Out of reset SDA is released, the pointer is 0x0 and every writable register holds 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | High pulls SDA low |
| port_pins_i | input | 8 | Live port pin levels, read at register 0x0 |

## Verification
The bench goes after the places where the pointer can drift. A design that stepped the pointer on the command byte, or reset the pointer at STOP, would return the wrong register in the read-after-write and command-only cases. One that cleared the pointer on a repeated START would read back the wrong location in every table row. The wrap from 0xF across the read-only location shows whether a design stores writes to 0x0 or skips the step there. Extra clocks after a host NACK, followed by a fresh read, show whether a design keeps driving SDA or moves the pointer again. Bytes cut off by a STOP or a repeated START, and traffic to a foreign address, show whether a partial or unaddressed byte reaches the register file.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WR,
    ST_ACK,
    ST_RD,
    ST_RACK,
    ST_SKIP
  } eng_st_e;
endpackage

// File: rtl/i2c_rp_line_sync.sv
module i2c_rp_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // one extra stage keeps the previous synchronised level
  logic [STAGES:0] scl_sh, sda_sh;
  logic scl_s, scl_q, sda_s, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  assign scl_s = scl_sh[STAGES-1];
  assign scl_q = scl_sh[STAGES];
  assign sda_s = sda_sh[STAGES-1];
  assign sda_q = sda_sh[STAGES];

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rp_regfile.sv
module i2c_rp_regfile #(
  parameter int NUM_REGS = 16,
  parameter int RO_IDX   = 0,
  parameter int DW       = 8,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  input  logic [DW-1:0] port_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] rd_vec [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DW-1:0] q;
    if (g == RO_IDX) begin : g_ro
      assign q = port_i;
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                            q <= '0;
        else if (we_i && waddr_i == AW'(g))     q <= wdata_i;
      end
    end
    assign rd_vec[g] = q;
  end

  assign rdata_o = rd_vec[raddr_i];
endmodule

// File: rtl/i2c_rp_engine.sv
module i2c_rp_engine
  import i2c_rp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3A,
  parameter int         AW       = 4,
  parameter int         RO_IDX   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic [AW-1:0]     ptr_o
);
  eng_st_e           state, after;
  logic [2:0]        cnt;
  logic [BYTE_W-1:0] sr;
  logic [AW-1:0]     ptr;
  logic              oe, ack_pend, rd_last, mack;
  logic [BYTE_W-1:0] nb;

  assign nb      = {sr[BYTE_W-2:0], sda_s_i};
  assign we_o    = (state == ST_WR) && scl_rise_i && (cnt == 3'd7) && !start_i && !stop_i
                   && (ptr != AW'(RO_IDX));
  assign waddr_o = ptr;
  assign wdata_o = nb;
  assign ptr_o   = ptr;
  assign sda_oe_o = oe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      after    <= ST_IDLE;
      cnt      <= '0;
      sr       <= '0;
      ptr      <= '0;
      oe       <= 1'b0;
      ack_pend <= 1'b0;
      rd_last  <= 1'b0;
      mack     <= 1'b0;
    end else if (start_i) begin
      state    <= ST_ADDR;
      cnt      <= '0;
      oe       <= 1'b0;
      ack_pend <= 1'b0;
      rd_last  <= 1'b0;
      mack     <= 1'b0;
    end else if (stop_i) begin
      state    <= ST_IDLE;
      oe       <= 1'b0;
      ack_pend <= 1'b0;
      rd_last  <= 1'b0;
      mack     <= 1'b0;
    end else if (scl_rise_i) begin
      unique case (state)
        ST_ADDR, ST_CMD, ST_WR: begin
          sr  <= nb;
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            if (state == ST_ADDR) begin
              if (nb[7:1] == DEV_ADDR) begin
                ack_pend <= 1'b1;
                after    <= nb[0] ? ST_RD : ST_CMD;
              end else begin
                state <= ST_SKIP;
              end
            end else if (state == ST_CMD) begin
              ptr      <= nb[AW-1:0];
              ack_pend <= 1'b1;
              after    <= ST_WR;
            end else begin
              ptr      <= ptr + AW'(1);
              ack_pend <= 1'b1;
              after    <= ST_WR;
            end
          end
        end
        ST_RD: begin
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) rd_last <= 1'b1;
        end
        ST_RACK: begin
          if (sda_s_i) state <= ST_SKIP;  // host NACK
          else         mack  <= 1'b1;
        end
        default: ;
      endcase
    end else if (scl_fall_i) begin
      if (ack_pend) begin
        oe       <= 1'b1;
        ack_pend <= 1'b0;
        state    <= ST_ACK;
      end else begin
        unique case (state)
          ST_ACK: begin
            cnt <= '0;
            if (after == ST_RD) begin
              sr    <= rdata_i;
              oe    <= ~rdata_i[BYTE_W-1];
              ptr   <= ptr + AW'(1);
              state <= ST_RD;
            end else begin
              oe    <= 1'b0;
              state <= after;
            end
          end
          ST_RD: begin
            if (rd_last) begin
              oe      <= 1'b0;
              rd_last <= 1'b0;
              mack    <= 1'b0;
              state   <= ST_RACK;
            end else begin
              sr <= {sr[BYTE_W-2:0], 1'b0};
              oe <= ~sr[BYTE_W-2];
            end
          end
          ST_RACK: begin
            if (mack) begin
              mack  <= 1'b0;
              cnt   <= '0;
              sr    <= rdata_i;
              oe    <= ~rdata_i[BYTE_W-1];
              ptr   <= ptr + AW'(1);
              state <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target
  import i2c_rp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter int         NUM_REGS    = 16,
  parameter int         RO_IDX      = 0,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [BYTE_W-1:0] port_pins_i
);
  logic              sda_s, scl_rise, scl_fall, start, stop;
  logic              we;
  logic [AW-1:0]     waddr, ptr;
  logic [BYTE_W-1:0] wdata, rdata;

  i2c_rp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  i2c_rp_engine #(.DEV_ADDR(DEV_ADDR), .AW(AW), .RO_IDX(RO_IDX)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .rdata_i    (rdata),
    .sda_oe_o   (sda_oe_o),
    .we_o       (we),
    .waddr_o    (waddr),
    .wdata_o    (wdata),
    .ptr_o      (ptr)
  );

  i2c_rp_regfile #(.NUM_REGS(NUM_REGS), .RO_IDX(RO_IDX), .DW(BYTE_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (ptr),
    .port_i  (port_pins_i),
    .rdata_o (rdata)
  );
endmodule

// File: rtl/i2c_regptr_target_chk.sv
module i2c_regptr_target_chk #(
  parameter int AW     = 4,
  parameter int RO_IDX = 0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sda_oe_i,
  input logic          scl_fall_i,
  input logic          start_i,
  input logic          stop_i,
  input logic          we_i,
  input logic [AW-1:0] waddr_i,
  input logic [AW-1:0] ptr_i
);
  assert_oe_on_edge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_i != $past(sda_oe_i)) |-> ($past(scl_fall_i) || $past(start_i) || $past(stop_i)));

  assert_release_on_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  assert_ptr_kept_on_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> $stable(ptr_i));

  assert_ro_not_written_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (waddr_i != AW'(RO_IDX)));

  assert_ptr_steps_on_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (ptr_i == AW'($past(ptr_i) + AW'(1))));
endmodule

bind i2c_regptr_target i2c_regptr_target_chk #(.AW(AW), .RO_IDX(RO_IDX)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_oe_i   (sda_oe_o),
  .scl_fall_i (scl_fall),
  .start_i    (start),
  .stop_i     (stop),
  .we_i       (we),
  .waddr_i    (waddr),
  .ptr_i      (ptr)
);

// File: tb/i2c_regptr_target_tb.sv
module i2c_regptr_target_tb;
  localparam logic [6:0] DEV = 7'h3A;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [7:0] pins = 8'h96;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] mirror [16];

  always #5 clk = ~clk;

  i2c_regptr_target u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .port_pins_i (pins)
  );

  // {pointer, data}
  localparam logic [11:0] VEC [6] = '{
    {4'h1, 8'hA5}, {4'h2, 8'h5A}, {4'h7, 8'h3C},
    {4'hF, 8'hFF}, {4'h8, 8'h69}, {4'hC, 8'h81}
  };

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; scl_m = 1'b1; hold(H);
    sda_m = 1'b0; hold(H);
    scl_m = 1'b0; hold(2);
  endtask

  task automatic bus_rstart;
    sda_m = 1'b1; hold(H);
    scl_m = 1'b1; hold(H);
    sda_m = 1'b0; hold(H);
    scl_m = 1'b0; hold(2);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; hold(H);
    scl_m = 1'b1; hold(H);
    sda_m = 1'b1; hold(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hold(H);
      scl_m = 1'b1; hold(H);
      scl_m = 1'b0; hold(2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; hold(H);
    scl_m = 1'b1; hold(H/2);
    ack = !sda_line;
    hold(H/2);
    scl_m = 1'b0; hold(2);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) begin
      hold(H);
      scl_m = 1'b1; hold(H/2);
      b[i] = sda_line;
      hold(H/2);
      scl_m = 1'b0; hold(2);
    end
    sda_m = nack; hold(H);
    scl_m = 1'b1; hold(H);
    scl_m = 1'b0; hold(2);
    sda_m = 1'b1;
  endtask

  task automatic tx_acked(input logic [7:0] b, input string tag);
    logic a;
    send_byte(b, a);
    chk(a, tag, {7'd0, a}, 8'h01);
  endtask

  // write command, repeated START, read one byte with NACK, STOP
  task automatic read_at(input logic [3:0] p, output logic [7:0] d);
    bus_start;
    tx_acked({DEV, 1'b0}, "R1 addr w");
    tx_acked({4'h0, p}, "R3 cmd");
    bus_rstart;
    tx_acked({DEV, 1'b1}, "R1 addr r");
    recv_byte(d, 1'b1);
    bus_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R12 act=%h exp=%h", 8'h00, 8'h01);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic a;
    for (int i = 0; i < 16; i++) mirror[i] = 8'h00;

    // R12: reset state
    hold(4);
    chk(sda_oe == 1'b0, "R12 oe in reset", {7'd0, sda_oe}, 8'h00);
    rst_ni = 1'b1;
    hold(4);
    chk(sda_oe == 1'b0, "R12 oe after reset", {7'd0, sda_oe}, 8'h00);
    bus_start;
    tx_acked({DEV, 1'b1}, "R1 addr r");
    recv_byte(d, 1'b0);
    chk(d == pins, "R12 ptr0 reads pins", d, pins);
    recv_byte(d, 1'b1);
    bus_stop;
    chk(d == 8'h00, "R12 reg1 reset", d, 8'h00);

    // R3 R8: table of write then repeated-START readback
    for (int v = 0; v < 6; v++) begin
      logic [3:0] p;
      logic [7:0] w;
      p = VEC[v][11:8];
      w = VEC[v][7:0];
      bus_start;
      tx_acked({DEV, 1'b0}, "R1 addr w");
      tx_acked({4'h0, p}, "R3 cmd ack");
      tx_acked(w, "R3 data ack");
      mirror[p] = w;
      bus_rstart;
      tx_acked({DEV, 1'b0}, "R1 addr w");
      tx_acked({4'h0, p}, "R3 cmd ack");
      bus_rstart;
      tx_acked({DEV, 1'b1}, "R8 addr r");
      recv_byte(d, 1'b1);
      bus_stop;
      chk(d == w, "R8 rstart readback", d, w);
    end

    // R4 R5 R9: burst across the wrap and the read-only location
    bus_start;
    tx_acked({DEV, 1'b0}, "R4 addr w");
    tx_acked(8'h0E, "R4 cmd");
    tx_acked(8'h11, "R4 data E");
    tx_acked(8'h22, "R4 data F");
    tx_acked(8'h33, "R9 write ro acked");
    tx_acked(8'h44, "R4 data 1");
    bus_stop;
    mirror[14] = 8'h11; mirror[15] = 8'h22; mirror[1] = 8'h44;
    bus_start;
    tx_acked({DEV, 1'b0}, "R5 addr w");
    tx_acked(8'h0E, "R5 cmd");
    bus_rstart;
    tx_acked({DEV, 1'b1}, "R5 addr r");
    recv_byte(d, 1'b0); chk(d == 8'h11, "R5 burst E", d, 8'h11);
    recv_byte(d, 1'b0); chk(d == 8'h22, "R5 burst F", d, 8'h22);
    recv_byte(d, 1'b0); chk(d == pins, "R4 wrap ro ignored", d, pins);
    recv_byte(d, 1'b1); chk(d == 8'h44, "R5 burst 1", d, 8'h44);
    bus_stop;

    // R6: pointer persists after a write
    bus_start;
    tx_acked({DEV, 1'b0}, "R6 addr w");
    tx_acked(8'h03, "R6 cmd");
    tx_acked(8'h66, "R6 data 3");
    tx_acked(8'h77, "R6 data 4");
    bus_stop;
    mirror[3] = 8'h66; mirror[4] = 8'h77;
    bus_start;
    tx_acked({DEV, 1'b1}, "R6 addr r");
    recv_byte(d, 1'b1);
    bus_stop;
    chk(d == mirror[5], "R6 read after write", d, mirror[5]);

    // R7: command-only write then STOP
    bus_start;
    tx_acked({DEV, 1'b0}, "R7 addr w");
    tx_acked(8'h07, "R7 cmd");
    bus_stop;
    bus_start;
    tx_acked({DEV, 1'b1}, "R7 addr r");
    recv_byte(d, 1'b0); chk(d == mirror[7], "R7 first", d, mirror[7]);
    recv_byte(d, 1'b1); chk(d == mirror[8], "R7 second", d, mirror[8]);
    bus_stop;

    // R9: live pins and ignored write
    pins = 8'h5A;
    read_at(4'h0, d); chk(d == 8'h5A, "R9 pins 5A", d, 8'h5A);
    pins = 8'hC3;
    read_at(4'h0, d); chk(d == 8'hC3, "R9 pins C3", d, 8'hC3);
    bus_start;
    tx_acked({DEV, 1'b0}, "R9 addr w");
    tx_acked(8'h00, "R9 cmd");
    tx_acked(8'hEE, "R9 ro write acked");
    bus_stop;
    read_at(4'h0, d); chk(d == 8'hC3, "R9 ro unchanged", d, 8'hC3);

    // R2: foreign address
    bus_start;
    send_byte({7'h21, 1'b0}, a); chk(!a, "R2 no addr ack", {7'd0, a}, 8'h00);
    send_byte(8'h02, a);         chk(!a, "R2 no cmd ack", {7'd0, a}, 8'h00);
    send_byte(8'h99, a);         chk(!a, "R2 no data ack", {7'd0, a}, 8'h00);
    bus_stop;
    read_at(4'h2, d); chk(d == mirror[2], "R2 reg unchanged", d, mirror[2]);

    // R10: NACK ends the read
    bus_start;
    tx_acked({DEV, 1'b0}, "R10 addr w");
    tx_acked(8'h0C, "R10 cmd");
    bus_rstart;
    tx_acked({DEV, 1'b1}, "R10 addr r");
    recv_byte(d, 1'b1); chk(d == mirror[12], "R10 byte", d, mirror[12]);
    recv_byte(d, 1'b1); chk(d == 8'hFF, "R10 released after nack", d, 8'hFF);
    bus_stop;
    chk(sda_oe == 1'b0, "R10 released at stop", {7'd0, sda_oe}, 8'h00);
    bus_start;
    tx_acked({DEV, 1'b1}, "R10 addr r");
    recv_byte(d, 1'b1);
    bus_stop;
    chk(d == mirror[13], "R10 ptr stepped once", d, mirror[13]);

    // R11: byte cut by STOP, then by repeated START
    bus_start;
    tx_acked({DEV, 1'b0}, "R11 addr w");
    tx_acked(8'h05, "R11 cmd");
    send_bits(8'hF0, 4);
    bus_stop;
    read_at(4'h5, d); chk(d == mirror[5], "R11 stop abort", d, mirror[5]);
    bus_start;
    tx_acked({DEV, 1'b0}, "R11 addr w");
    tx_acked(8'h06, "R11 cmd");
    send_bits(8'hAB, 5);
    bus_rstart;
    tx_acked({DEV, 1'b0}, "R11 addr w");
    tx_acked(8'h06, "R11 cmd");
    bus_rstart;
    tx_acked({DEV, 1'b1}, "R11 addr r");
    recv_byte(d, 1'b1);
    bus_stop;
    chk(d == mirror[6], "R11 start abort", d, mirror[6]);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule